// File: doc/BRIEF.md
# Write-Protected Timer Enable Controller

This block owns the run flags of a bank of down-counting timer channels (eleven by default). Software sees a 16-bit enable register with one bit per channel. A software write to a channel's bit counts only when that channel's write-protect flag is clear. A channel can also be started by hardware: when its external-start option is selected, a rising edge on that channel's event input sets its run flag. When a counter reports underflow, the block clears that channel's run flag, unless the channel is in continuous mode. Reading the enable register therefore shows which channels are counting and which are idle.

The protect flags and the external-start selects sit in two companion 16-bit registers that use the same bit layout as the enable register. All three registers accept only full-halfword writes. A narrower write changes nothing and raises a one-cycle access-error pulse. The counters are not part of this block: their underflow pulses and continuous-mode flags come in as inputs, and the run flags go out on `count_en`.

Top module: `tmr_enable_ctrl`

## Requirements
- R1: After synchronous reset, `count_en`, the protect register, the external-select register and `acc_err` are all zero.
- R2: Register addresses are 0 = enable, 1 = protect, 2 = external select, 3 = reserved (reads 0, writes ignored). Channel n sits in data bit n, so channel 0 is the LSB. Bits 15:11 always read 0. A read of address 0 returns the live `count_en` value in the same cycle.
- R3: A write to address 0 with `wr_strb` = 2'b11 sets `count_en[n]` to `wr_data[n]` on the next rising edge, for every channel whose protect bit is 0. A 1 starts the channel and a 0 stops it.
- R4: For a channel whose protect bit is 1, a write to address 0 leaves its enable bit unchanged.
- R5: An underflow pulse `uflow[n]` with `cont[n]` = 0 clears `count_en[n]` on the next edge. With `cont[n]` = 1, the underflow has no effect.
- R6: An underflow clear takes priority over a software write of 1 to the same channel in the same cycle.
- R7: With external-select bit n = 1, the first cycle in which `ext_in[n]` is seen high after being low sets `count_en[n]` on that edge. A level held high does not set the bit again. With the select bit at 0, `ext_in[n]` has no effect.
- R8: A software write that reaches a channel (protect = 0) takes priority over an external start arriving in the same cycle.
- R9: A write with `wr_strb` other than 2'b11 changes no register. It drives `acc_err` high for exactly the one cycle after the write.
- R10: The protect and external-select registers take halfword writes at any time and read back their channel bits, with bits 15:11 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 2 | Write register address |
| wr_strb | input | 2 | Byte strobes; both must be set |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Read data (combinational) |
| uflow | input | 11 | Per-channel underflow pulses |
| cont | input | 11 | Per-channel continuous-mode flags |
| ext_in | input | 11 | Per-channel external start inputs |
| count_en | output | 11 | Per-channel run flags |
| acc_err | output | 1 | One-cycle pulse after a partial-width write |

## Verification
Every register result is due one edge after its stimulus: a write, an underflow, an external rising edge or a partial-width access. `rd_data` is combinational from the registers and is valid in the same cycle as the address. The bench applies each stimulus a short time after the falling edge. It advances one rising edge, waits a short settle time, and then compares `count_en`, `acc_err` and `rd_data` against a bench model stepped with the same inputs. Directed cases put underflow, write and external start in one cycle to exercise each priority, and a long random run mixes all stimuli at the same one-edge spacing.

// File: rtl/tec_pkg.sv
package tec_pkg;

    localparam int REG_W  = 16;
    localparam int STRB_W = 2;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_RUN  = 2'd0,
        ADDR_LOCK = 2'd1,
        ADDR_XSEL = 2'd2,
        ADDR_RSVD = 2'd3
    } reg_addr_e;

    // decoded, validated write request
    typedef struct packed {
        logic             run_wr;
        logic             lock_wr;
        logic             xsel_wr;
        logic [REG_W-1:0] data;
    } wr_req_t;

    // source chosen for a channel's next run flag value
    typedef enum logic [1:0] {
        NX_HOLD  = 2'd0,
        NX_CLEAR = 2'd1,
        NX_LOAD  = 2'd2,
        NX_SET   = 2'd3
    } nx_src_e;

    function automatic logic full_access(input logic [STRB_W-1:0] strb);
        return &strb;
    endfunction

    function automatic nx_src_e pick_next(input logic uf_clear,
                                          input logic sw_hit,
                                          input logic ext_hit);
        if (uf_clear)     return NX_CLEAR;
        else if (sw_hit)  return NX_LOAD;
        else if (ext_hit) return NX_SET;
        else              return NX_HOLD;
    endfunction

endpackage

// File: rtl/tec_bus_dec.sv
module tec_bus_dec
    import tec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [REG_W-1:0]  wr_data,
    output wr_req_t           req,
    output logic              acc_err
);
    logic ok;
    logic bad;

    always_comb begin
        ok          = wr_en && full_access(wr_strb);
        bad         = wr_en && !full_access(wr_strb);
        req         = '0;
        req.data    = wr_data;
        req.run_wr  = ok && (reg_addr_e'(wr_addr) == ADDR_RUN);
        req.lock_wr = ok && (reg_addr_e'(wr_addr) == ADDR_LOCK);
        req.xsel_wr = ok && (reg_addr_e'(wr_addr) == ADDR_XSEL);
    end

    always_ff @(posedge clk) begin
        if (rst) acc_err <= 1'b0;
        else     acc_err <= bad;
    end
endmodule

// File: rtl/tec_edge_det.sv
module tec_edge_det #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/tec_chan_cell.sv
module tec_chan_cell
    import tec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic uflow,
    input  logic cont,
    input  logic locked,
    input  logic xsel,
    input  logic ext_rise,
    input  logic sw_wr,
    input  logic sw_bit,
    output logic run_q
);
    nx_src_e src;

    always_comb begin
        src = pick_next(uflow && !cont, sw_wr && !locked, ext_rise && xsel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else begin
            unique case (src)
                NX_CLEAR: run_q <= 1'b0;
                NX_LOAD:  run_q <= sw_bit;
                NX_SET:   run_q <= 1'b1;
                default:  run_q <= run_q;
            endcase
        end
    end
endmodule

// File: rtl/tmr_enable_ctrl.sv
module tmr_enable_ctrl
    import tec_pkg::*;
#(
    parameter int NUM_CH = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [1:0]        wr_strb,
    input  logic [15:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [15:0]       rd_data,
    input  logic [NUM_CH-1:0] uflow,
    input  logic [NUM_CH-1:0] cont,
    input  logic [NUM_CH-1:0] ext_in,
    output logic [NUM_CH-1:0] count_en,
    output logic              acc_err
);
    localparam int PAD_W = REG_W - NUM_CH;

    wr_req_t           req;
    logic [NUM_CH-1:0] prot_q;
    logic [NUM_CH-1:0] xsel_q;
    logic [NUM_CH-1:0] ext_rise;

    tec_bus_dec u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_strb (wr_strb),
        .wr_data (wr_data),
        .req     (req),
        .acc_err (acc_err)
    );

    tec_edge_det #(.N(NUM_CH)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ext_in),
        .rise (ext_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= '0;
            xsel_q <= '0;
        end else begin
            if (req.lock_wr) prot_q <= req.data[NUM_CH-1:0];
            if (req.xsel_wr) xsel_q <= req.data[NUM_CH-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tec_chan_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .uflow    (uflow[c]),
            .cont     (cont[c]),
            .locked   (prot_q[c]),
            .xsel     (xsel_q[c]),
            .ext_rise (ext_rise[c]),
            .sw_wr    (req.run_wr),
            .sw_bit   (req.data[c]),
            .run_q    (count_en[c])
        );
    end

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            ADDR_RUN:  rd_data = {{PAD_W{1'b0}}, count_en};
            ADDR_LOCK: rd_data = {{PAD_W{1'b0}}, prot_q};
            ADDR_XSEL: rd_data = {{PAD_W{1'b0}}, xsel_q};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tec_checker.sv
module tec_checker #(
    parameter int NUM_CH = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [1:0]        wr_strb,
    input logic [15:0]       wr_data,
    input logic [1:0]        rd_addr,
    input logic [15:0]       rd_data,
    input logic [NUM_CH-1:0] uflow,
    input logic [NUM_CH-1:0] cont,
    input logic [NUM_CH-1:0] ext_in,
    input logic [NUM_CH-1:0] count_en,
    input logic              acc_err,
    input logic [NUM_CH-1:0] prot_q,
    input logic [NUM_CH-1:0] xsel_q
);
    AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (count_en == '0 && !acc_err && prot_q == '0)); // R1
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst) rd_data[15:NUM_CH] == '0); // R2
    AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_strb != 2'b11) |=> acc_err); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst) acc_err |-> $past(wr_en && wr_strb != 2'b11)); // R9
    AST_PROT_NOWRITE: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_strb != 2'b11) |=> ($stable(prot_q) && $stable(xsel_q))); // R9

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_UFLOW_CLEAR: assert property (@(posedge clk) disable iff (rst) (uflow[c] && !cont[c]) |=> !count_en[c]); // R5
        AST_SW_LOAD: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_addr == 2'd0 && wr_strb == 2'b11 && !prot_q[c] && !uflow[c]) |=> (count_en[c] == $past(wr_data[c]))); // R3
        AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_addr == 2'd0 && prot_q[c] && !uflow[c] && !xsel_q[c]) |=> $stable(count_en[c])); // R4
        AST_EXT_OFF: assert property (@(posedge clk) disable iff (rst) (!xsel_q[c] && !(wr_en && wr_addr == 2'd0) && !uflow[c]) |=> $stable(count_en[c])); // R7
    end
endmodule

bind tmr_enable_ctrl tec_checker #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/tmr_enable_ctrl_tb_top.sv
`timescale 1ns/1ps
module tmr_enable_ctrl_tb_top;
    localparam int NCH = 11;

    logic           clk = 1'b0;
    logic           rst;
    logic           wr_en;
    logic [1:0]     wr_addr, wr_strb, rd_addr;
    logic [15:0]    wr_data, rd_data;
    logic [NCH-1:0] uflow, cont, ext_in, count_en;
    logic           acc_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    logic [NCH-1:0] m_en, m_prot, m_xsel, m_prev;
    logic           m_err;

    always #2.5 clk = ~clk;

    tmr_enable_ctrl #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .uflow(uflow),
        .cont(cont), .ext_in(ext_in), .count_en(count_en), .acc_err(acc_err)
    );

    function automatic logic [NCH-1:0] next_run(
        input logic [NCH-1:0] en, prot, xsel, prev,
        input logic we, input logic [1:0] a, s, input logic [15:0] d,
        input logic [NCH-1:0] uf, ct, ex);
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) begin
            if (uf[c] && !ct[c])                               r[c] = 1'b0;
            else if (we && a == 2'd0 && s == 2'b11 && !prot[c]) r[c] = d[c];
            else if (xsel[c] && ex[c] && !prev[c])             r[c] = 1'b1;
            else                                               r[c] = en[c];
        end
        return r;
    endfunction

    function automatic logic [15:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return {5'b0, m_en};
            2'd1:    return {5'b0, m_prot};
            2'd2:    return {5'b0, m_xsel};
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply inputs, advance one edge, update model, compare
    task automatic step(input logic we, input logic [1:0] a, input logic [1:0] s,
                        input logic [15:0] d, input logic [NCH-1:0] uf,
                        input logic [NCH-1:0] ct, input logic [NCH-1:0] ex,
                        input string tag);
        wr_en = we; wr_addr = a; wr_strb = s; wr_data = d;
        uflow = uf; cont = ct; ext_in = ex;
        @(posedge clk);
        m_en  = next_run(m_en, m_prot, m_xsel, m_prev, we, a, s, d, uf, ct, ex);
        m_err = we && s != 2'b11;
        if (we && s == 2'b11 && a == 2'd1) m_prot = d[NCH-1:0];
        if (we && s == 2'b11 && a == 2'd2) m_xsel = d[NCH-1:0];
        m_prev = ex;
        #1;
        check(tag, 32'(count_en), 32'(m_en));
        check("R9", 32'(acc_err), 32'(m_err));
        @(negedge clk);
        #0.5;
    endtask

    task automatic rd_check(input logic [1:0] a, input string tag);
        rd_addr = a;
        #0.5;
        check(tag, 32'(rd_data), 32'(model_read(a)));
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_strb = 0; wr_data = 0; rd_addr = 0;
        uflow = 0; cont = 0; ext_in = 0;
        m_en = 0; m_prot = 0; m_xsel = 0; m_prev = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #0.5;

        // R1 reset state
        check("R1", 32'(count_en), 0);
        check("R1", 32'(acc_err), 0);
        rd_check(2'd1, "R1");
        rd_check(2'd2, "R1");

        // R3 plain write start/stop, R2 readback
        step(1, 2'd0, 2'b11, 16'hFFFF, 0, 0, 0, "R3");
        check("R3", 32'(count_en), 32'h7FF);
        rd_check(2'd0, "R2");
        check("R2", 32'(rd_data[15:11]), 0);
        step(1, 2'd0, 2'b11, 16'h0005, 0, 0, 0, "R3");
        check("R3", 32'(count_en), 32'h005);
        rd_check(2'd3, "R2");

        // R10 protect register readback; R4 protected bits hold
        step(1, 2'd1, 2'b11, 16'hFF0F, 0, 0, 0, "R10");
        rd_check(2'd1, "R10");
        check("R10", 32'(rd_data), 32'h070F);
        step(1, 2'd0, 2'b11, 16'h07F0, 0, 0, 0, "R4");
        check("R4", 32'(count_en), 32'h0F5);

        // R9 byte write ignored and pulses once
        step(1, 2'd1, 2'b01, 16'h0000, 0, 0, 0, "R9");
        check("R9", 32'(acc_err), 1);
        rd_check(2'd1, "R9");
        step(0, 2'd0, 2'b00, 16'h0000, 0, 0, 0, "R9");
        check("R9", 32'(acc_err), 0);
        step(1, 2'd1, 2'b11, 16'h0000, 0, 0, 0, "R10");

        // R5 underflow clears, continuous mode keeps
        step(1, 2'd0, 2'b11, 16'h0003, 0, 0, 0, "R3");
        step(0, 2'd0, 2'b00, 16'h0000, 11'h003, 11'h002, 0, "R5");
        check("R5", 32'(count_en), 32'h002);

        // R6 underflow beats write of 1
        step(1, 2'd0, 2'b11, 16'h0004, 11'h004, 0, 0, "R6");
        check("R6", 32'(count_en[2]), 0);

        // R7 external start with select; not re-armed while held; ignored without select
        step(1, 2'd2, 2'b11, 16'h0010, 0, 0, 0, "R10");
        step(1, 2'd0, 2'b11, 16'h0000, 0, 0, 0, "R3");
        step(0, 2'd0, 2'b00, 16'h0000, 0, 0, 11'h030, "R7");
        check("R7", 32'(count_en), 32'h010);
        step(0, 2'd0, 2'b00, 16'h0000, 11'h010, 0, 11'h030, "R7");
        step(0, 2'd0, 2'b00, 16'h0000, 0, 0, 11'h030, "R7");
        check("R7", 32'(count_en), 0);

        // R8 write of 0 beats external start
        step(0, 2'd0, 2'b00, 16'h0000, 0, 0, 0, "R7");
        step(1, 2'd0, 2'b11, 16'h0000, 0, 0, 11'h010, "R8");
        check("R8", 32'(count_en[4]), 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] sa;
            sa = ($urandom % 8 == 0) ? 2'($urandom) : 2'b11;
            step(($urandom % 3) == 0, 2'($urandom), sa, 16'($urandom),
                 NCH'($urandom & $urandom & $urandom), NCH'($urandom),
                 NCH'($urandom & $urandom), "R3");
            rd_check(2'($urandom), "R2");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule